// File: doc/BRIEF.md
# Multiplexed Bus Address Decoder and Byte Ports

This block sits on the slave side of an external bus. On that bus a single 8-bit lane carries the low address byte first and then the data byte, and a separate 8-bit bus carries the high address byte. While the address-latch strobe is high, the block lets the lane byte through. When the strobe falls, it holds that byte. It joins the held byte with the live high byte to form a 16-bit address.

From that address and the active-low read and write strobes, the block produces the following outputs:
- an active-low chip select that maps RAM onto the lower half of the space;
- eight active-low peripheral selects;
- a byte input port and a byte output port that share one address;
- register-select, read/write and enable lines for a character display controller.

All bus pins are sampled on the block clock. The tri-state lane is modelled as a data output together with an output enable.

Top module: `busdec_top`

## Requirements
- R1: While `ale` is 1, `addr_full[7:0]` equals `lane_in` in the same cycle. `addr_full[15:8]` always equals `addr_hi`.
- R2: While `ale` is 0, `addr_full[7:0]` keeps the last byte seen with `ale` high, whatever `lane_in` does.
- R3: `ram_cs_n` equals address bit 15, so RAM is selected for 0000h–7FFFh.
- R4: When bit 15 is 1, exactly one bit of `dev_sel_n` is 0, at index {A10,A9,A8}. When bit 15 is 0, all eight bits are 1.
- R5: Address bits 11–14 and the low address byte have no effect on `dev_sel_n`.
- R6: `lcd_rs` equals address bit 12, and `lcd_rw` equals address bit 13.
- R7: `lcd_en` is 1 exactly when `dev_sel_n[7]` is 0 and `rd_n` or `wr_n` is 0.
- R8: `lane_oe` is 1 only when `rd_n` is 0, `wr_n` is 1 and `dev_sel_n[0]` is 0. In that case `lane_out` equals `in_port`.
- R9: A write to a select-0 address (e.g. 8000h) loads `out_port` at the clock where `wr_n` is first seen high again. The value loaded is the lane byte sampled on the last clock while `wr_n` was low. Before that clock, `out_port` is unchanged.
- R10: Writes to other addresses, and reads at the select-0 address, leave `out_port` unchanged.
- R11: A synchronous reset (`rst_n` low at a clock edge) clears `out_port` and the held low address byte to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples all bus pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ale | input | 1 | Address-latch strobe, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr_hi | input | 8 | High address byte A15..A8 |
| lane_in | input | 8 | Multiplexed address/data lane, as received |
| lane_out | output | 8 | Data driven onto the lane during input-port reads |
| lane_oe | output | 1 | Lane output enable |
| in_port | input | 8 | Byte input port pins |
| out_port | output | 8 | Byte output port register |
| addr_full | output | 16 | Assembled 16-bit address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| dev_sel_n | output | 8 | Decoded peripheral selects, active low |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write line |
| lcd_en | output | 1 | Display enable, active high |

## Verification
The bench drives full bus cycles in which the lane switches to unrelated data after the strobe falls. A latch that kept following the lane would then show a wrong low address byte. Decode vectors set the high byte to values whose bits 11–14 and low byte are not zero. A decoder that read the wrong bits, or that ignored bit 15 as an enable, would assert a wrong select or more than one select. Directed cases check the timing of the output-port write, the effect of writes to neighbouring selects, and a read at the shared address. A design that loaded on the falling write strobe, or that answered reads at the shared address, would change `out_port` at the wrong moment. The bench also checks that the lane stays undriven during a display read and during a write.

// File: rtl/busdec_pkg.sv
// Package: shared widths and small helpers for the bus decode block.
// Assumes an 8-bit multiplexed lane and a 16-bit address space.
package busdec_pkg;
    localparam int LANE_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int SEL_W   = 3;
    localparam int NSEL    = 1 << SEL_W;
    localparam int SEL_LSB = 8;   // A8 is the lowest select input
    localparam int EN_BIT  = 15;  // A15 gates the decode
    localparam int RS_BIT  = 12;
    localparam int RW_BIT  = 13;
    localparam int IN_SEL  = 0;   // select index shared by the byte ports
    localparam int LCD_SEL = 7;   // select index of the display

    typedef logic [LANE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/busdec_addr_latch.sv
// Low address latch: follows the lane while ale is high and holds it while
// ale is low. The held byte is joined with the live high byte.
// Assumes ale and lane_in are sampled on clk (the bus is oversampled).
module busdec_addr_latch
    import busdec_pkg::*;
#(
    parameter int LW = LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale,
    input  logic [LW-1:0] lane_in,
    input  logic [LW-1:0] addr_hi,
    output logic [2*LW-1:0] addr_full
);
    logic [LW-1:0] lo_q;

    // Hold register: refreshes from the lane while ale is high.
    always_ff @(posedge clk) begin
        if (!rst_n)   lo_q <= '0;
        else if (ale) lo_q <= lane_in;
    end

    // Transparent path: live lane while ale is high, held byte otherwise.
    always_comb begin
        addr_full = {addr_hi, (ale ? lane_in : lo_q)};
    end

    // R2
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !ale) |=> $stable(lo_q));
endmodule

// File: rtl/busdec_decode.sv
// Address decoder: 3-to-8 selects enabled by the top address bit, plus the
// RAM select for the lower half and the display control lines.
// Assumes a full address from the latch; purely combinational outputs.
module busdec_decode
    import busdec_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SEL_W,
    parameter int SL = SEL_LSB,
    parameter int EB = EN_BIT,
    localparam int NS = 1 << SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic          ram_cs_n,
    output logic [NS-1:0] sel_n,
    output logic          rs,
    output logic          rw
);
    logic [SW-1:0] idx;
    logic          en;

    // Select field and enable taken from the address.
    always_comb begin
        idx = addr[SL +: SW];
        en  = addr[EB];
    end

    // One active-low select per index, only while enabled.
    for (genvar g = 0; g < NS; g++) begin : g_sel
        always_comb sel_n[g] = !(en && (idx == SW'(g)));
    end

    // RAM select and display register lines.
    always_comb begin
        ram_cs_n = addr[EB];
        rs       = addr[RS_BIT];
        rw       = addr[RW_BIT];
    end

    // R4
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));
    // R3
    ram_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cs_n |-> (&sel_n));
endmodule

// File: rtl/busdec_out_port.sv
// Output port register: loads the lane byte when a write strobe at its
// address ends (rising wr_n). The data and select are taken from the last
// cycle with wr_n low. Assumes wr_n is sampled on clk.
module busdec_out_port
    import busdec_pkg::*;
#(
    parameter int LW = LANE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          sel,
    input  logic [LW-1:0] lane_in,
    output logic [LW-1:0] port_q
);
    logic          wr_q;
    logic          hit_q;
    logic [LW-1:0] dat_q;
    logic          rise;

    // Edge detect on the returning write strobe.
    always_comb rise = !wr_q && wr_n;

    // History of strobe, address hit and lane data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= 1'b1;
            hit_q <= 1'b0;
            dat_q <= '0;
        end else begin
            wr_q  <= wr_n;
            hit_q <= sel && !wr_n;
            dat_q <= lane_in;
        end
    end

    // Port register: load on the end of a write that hit this address.
    always_ff @(posedge clk) begin
        if (!rst_n)             port_q <= '0;
        else if (rise && hit_q) port_q <= dat_q;
    end

    // R10
    port_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rise) |=> $stable(port_q));
endmodule

// File: rtl/busdec_top.sv
// Top: bus-side glue for a multiplexed address/data bus. Latches the low
// address, decodes selects, and serves the input port, the output port and
// the display control lines. The lane is modelled as data plus an enable.
module busdec_top
    import busdec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ale,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [7:0]  addr_hi,
    input  logic [7:0]  lane_in,
    output logic [7:0]  lane_out,
    output logic        lane_oe,
    input  logic [7:0]  in_port,
    output logic [7:0]  out_port,
    output logic [15:0] addr_full,
    output logic        ram_cs_n,
    output logic [7:0]  dev_sel_n,
    output logic        lcd_rs,
    output logic        lcd_rw,
    output logic        lcd_en
);
    logic any_strobe;
    logic rd_only;

    busdec_addr_latch #(.LW(LANE_W)) latch_i (
        .clk(clk), .rst_n(rst_n), .ale(ale), .lane_in(lane_in),
        .addr_hi(addr_hi), .addr_full(addr_full)
    );

    busdec_decode #(.AW(ADDR_W), .SW(SEL_W), .SL(SEL_LSB), .EB(EN_BIT)) dec_i (
        .clk(clk), .rst_n(rst_n), .addr(addr_full), .ram_cs_n(ram_cs_n),
        .sel_n(dev_sel_n), .rs(lcd_rs), .rw(lcd_rw)
    );

    busdec_out_port #(.LW(LANE_W)) oport_i (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel(!dev_sel_n[IN_SEL]),
        .lane_in(lane_in), .port_q(out_port)
    );

    // Strobe qualifiers.
    always_comb begin
        any_strobe = !rd_n || !wr_n;
        rd_only    = !rd_n && wr_n;
    end

    // Input port onto the lane and display enable.
    always_comb begin
        lane_oe  = rd_only && !dev_sel_n[IN_SEL];
        lane_out = lane_oe ? in_port : '0;
        lcd_en   = any_strobe && !dev_sel_n[LCD_SEL];
    end

    // R8
    lane_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_oe |-> (!rd_n && wr_n && !ram_cs_n == 1'b0 && addr_full[15]));
    // R7
    lcd_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_en |-> (addr_full[15] && (&addr_full[10:8])));
endmodule

// File: tb/busdec_top_tb_top.sv
`timescale 1ns/1ps
module busdec_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  addr_hi = '0, lane_in = '0, in_port = '0;
    logic [7:0]  lane_out, out_port, dev_sel_n;
    logic        lane_oe, ram_cs_n, lcd_rs, lcd_rw, lcd_en;
    logic [15:0] addr_full;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    busdec_top dut_i (
        .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .addr_hi(addr_hi), .lane_in(lane_in), .lane_out(lane_out),
        .lane_oe(lane_oe), .in_port(in_port), .out_port(out_port),
        .addr_full(addr_full), .ram_cs_n(ram_cs_n), .dev_sel_n(dev_sel_n),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Address phase then strobe; checks are made by the caller afterwards.
    task automatic addr_phase(input logic [15:0] a, input logic [7:0] data,
                              input logic rd, input logic wr);
        @(negedge clk);
        ale = 1'b1; lane_in = a[7:0]; addr_hi = a[15:8];
        @(negedge clk);
        ale = 1'b0; lane_in = data; rd_n = !rd; wr_n = !wr;
        @(negedge clk);
        #1;
    endtask

    task automatic release_bus();
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        #1;
    endtask

    // {address, ram_cs_n, dev_sel_n, rs, rw}
    localparam logic [26:0] VEC [10] = '{
        {16'h0000, 1'b0, 8'hFF, 1'b0, 1'b0},
        {16'h7FFF, 1'b0, 8'hFF, 1'b1, 1'b1},
        {16'h8000, 1'b1, 8'hFE, 1'b0, 1'b0},
        {16'h8155, 1'b1, 8'hFD, 1'b0, 1'b0},
        {16'h8700, 1'b1, 8'h7F, 1'b0, 1'b0},
        {16'hF8FF, 1'b1, 8'hFE, 1'b1, 1'b1},
        {16'hCFFF, 1'b1, 8'h7F, 1'b0, 1'b0},
        {16'hB7AA, 1'b1, 8'h7F, 1'b1, 1'b1},
        {16'h9A00, 1'b1, 8'hFB, 1'b1, 1'b0},
        {16'hE300, 1'b1, 8'hF7, 1'b0, 1'b1}
    };

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        chk("R11 out_port reset", {8'h0, out_port}, 16'h0000);
        chk("R11 latch reset", addr_full, 16'h0000);
        rst_n = 1'b1;

        // R1: transparency in the same cycle
        @(negedge clk);
        ale = 1'b1; lane_in = 8'h3C; addr_hi = 8'h12;
        #1;
        chk("R1 transparent", addr_full, 16'h123C);
        lane_in = 8'hC3;
        #1;
        chk("R1 follows lane", addr_full, 16'h12C3);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 10; i++) begin
            addr_phase(VEC[i][26:11], ~VEC[i][18:11], 1'b0, 1'b0);
            chk("R2 held low byte", addr_full, VEC[i][26:11]);
            chk("R3 ram select", {15'h0, ram_cs_n}, {15'h0, VEC[i][10]});
            chk("R4 R5 selects", {8'h0, dev_sel_n}, {8'h0, VEC[i][9:2]});
            chk("R6 rs/rw", {14'h0, lcd_rs, lcd_rw}, {14'h0, VEC[i][1:0]});
            chk("R7 no strobe no enable", {15'h0, lcd_en}, 16'h0);
        end

        // R8: input port read at 8000h
        in_port = 8'hA5;
        addr_phase(16'h8000, 8'h00, 1'b1, 1'b0);
        chk("R8 lane_oe on read", {15'h0, lane_oe}, 16'h1);
        chk("R8 lane data", {8'h0, lane_out}, 16'h00A5);
        chk("R7 enable off", {15'h0, lcd_en}, 16'h0);
        release_bus();
        chk("R8 oe off after read", {15'h0, lane_oe}, 16'h0);
        chk("R10 read leaves port", {8'h0, out_port}, 16'h0000);

        // R7 R8: display read
        addr_phase(16'h8700, 8'h00, 1'b1, 1'b0);
        chk("R7 lcd read enable", {15'h0, lcd_en}, 16'h1);
        chk("R8 no drive on lcd read", {15'h0, lane_oe}, 16'h0);
        release_bus();
        chk("R7 enable drops", {15'h0, lcd_en}, 16'h0);

        // R9: write to 8000h
        addr_phase(16'h8000, 8'h5A, 1'b0, 1'b1);
        chk("R8 no drive on write", {15'h0, lane_oe}, 16'h0);
        chk("R9 unchanged before strobe ends", {8'h0, out_port}, 16'h0000);
        release_bus();
        chk("R9 loaded after strobe", {8'h0, out_port}, 16'h005A);

        // R10: writes elsewhere
        addr_phase(16'h8100, 8'h11, 1'b0, 1'b1);
        release_bus();
        chk("R10 other select write", {8'h0, out_port}, 16'h005A);
        addr_phase(16'h0000, 8'h22, 1'b0, 1'b1);
        chk("R3 ram write select", {15'h0, ram_cs_n}, 16'h0);
        release_bus();
        chk("R10 ram write", {8'h0, out_port}, 16'h005A);
        addr_phase(16'hCFFF, 8'h33, 1'b0, 1'b1);
        chk("R7 lcd write enable", {15'h0, lcd_en}, 16'h1);
        release_bus();
        chk("R10 lcd write", {8'h0, out_port}, 16'h005A);

        // R9: second write at the alias F8FFh
        addr_phase(16'hF8FF, 8'h96, 1'b0, 1'b1);
        release_bus();
        chk("R9 alias write", {8'h0, out_port}, 16'h0096);

        // R11: reset in operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R11 port cleared", {8'h0, out_port}, 16'h0000);
        rst_n = 1'b1;

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule